// File: doc/BRIEF.md
# Swept Carrier-Frequency Acquisition Controller

This block finds a coarse carrier-frequency offset before fine phase tracking begins. It drives the frequency word of a single numerically controlled oscillator and steps it through a programmable list of search points. Each point is spaced by a step word that the integrator chooses to be smaller than the pull-in range of the carrier-phase loop that follows. At every point it measures the energy of the downconverted complex baseband samples. The matched filter is modelled as an integrate-and-dump accumulator that sums I squared plus Q squared over a programmable number of valid samples.

One downconverter and one energy detector are shared in time across the whole offset range. When the energy of a dwell strictly exceeds a programmable threshold, the sweep halts and the frequency word is frozen at that point. The block then raises a locked flag and reports the index of the held point, so that the downstream phase loop can take over from the coarse tuning. If the final point passes with no detection, the sweep returns to the start frequency and a sweep counter increments. A start pulse launches a search from idle, and a synchronous clear restarts it from any state.

Top module: `carrier_sweep_acq`

## Requirements
- R1: While reset is asserted and after its release, ncoFreq, stepIndex and sweepCount are 0, and searching and locked are 0.
- R2: A start pulse in the idle state makes the block search on the next cycle: searching=1, ncoFreq=cfgStartFreq, stepIndex=0, sweepCount=0.
- R3: The energy of one dwell is the sum of I*I+Q*Q over exactly cfgDwell samples that have sampleValid=1. Cycles with sampleValid=0 are not counted. A cfgDwell of 0 behaves as 1.
- R4: When a dwell ends with energy less than or equal to cfgThreshold and stepIndex is not the last point, then on the cycle after the last sample ncoFreq increases by cfgStepFreq (modulo 2^FREQ_W) and stepIndex increases by 1.
- R5: When a dwell ends with no detection at stepIndex = cfgNumSteps-1, the next cycle has ncoFreq=cfgStartFreq, stepIndex=0 and sweepCount incremented. A cfgNumSteps of 0 behaves as 1.
- R6: When a dwell ends with energy strictly greater than cfgThreshold, then on the next cycle locked=1 and searching=0, while ncoFreq and stepIndex keep the values of the detected point.
- R7: While locked, samples and start pulses have no effect: locked, ncoFreq and stepIndex stay unchanged until a clear.
- R8: A clear from any state, including while locked and including a clear in the same cycle as start, gives searching=1, locked=0, ncoFreq=cfgStartFreq, stepIndex=0 and sweepCount=0 on the next cycle.
- R9: The energy accumulator is ENERGY_W bits wide and saturates at 2^ENERGY_W-1 instead of wrapping.
- R10: The accumulator clears at every frequency change, so energy from one point never adds into the next.
- R11: A start pulse while searching has no effect on ncoFreq or stepIndex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart from the start frequency |
| start | input | 1 | Start pulse; acts only in the idle state |
| sampleValid | input | 1 | Qualifies sampleI and sampleQ |
| sampleI | input | SAMPLE_W | In-phase sample, signed |
| sampleQ | input | SAMPLE_W | Quadrature sample, signed |
| cfgStartFreq | input | FREQ_W | First frequency word of the search |
| cfgStepFreq | input | FREQ_W | Increment between search points |
| cfgNumSteps | input | STEP_W | Number of search points |
| cfgDwell | input | DWELL_W | Valid samples per dwell |
| cfgThreshold | input | ENERGY_W | Detection threshold; detection requires energy strictly above it |
| ncoFreq | output | FREQ_W | Oscillator frequency word |
| searching | output | 1 | Sweep in progress |
| locked | output | 1 | Peak detected and frequency held |
| stepIndex | output | STEP_W | Index of the current point, or of the held point when locked |
| sweepCount | output | SWEEP_W | Number of complete sweeps without detection |

## Verification
The embedded assertions check on every cycle that the frequency word and the locked flag stay put once lock is taken, that the accumulator never decreases while it integrates (so it cannot wrap), and that the control never asks the datapath to integrate, step and wrap at the same time. Only the bench scenarios can show the actual arithmetic. These cover the exact dwell count across gaps in sampleValid, the strict comparison at the threshold, stepping and wrap of the frequency word, the sweep counter, the index at which the search halts, saturation of a dwell whose true energy is above 2^32, and the precedence of clear over start.

// File: rtl/sweep_acq_pkg.sv
package sweep_acq_pkg;
  typedef struct packed {
    logic load;     // restart from the start frequency
    logic accum;    // integrate the current sample
    logic dump;     // dwell finished: clear accumulator
    logic advance;  // move to the next search point
    logic wrap;     // return to the first point, count a sweep
  } sweep_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_LOCK   = 2'd2
  } sweep_state_t;
endpackage

// File: rtl/sweep_datapath.sv
module sweep_datapath
  import sweep_acq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int FREQ_W   = 24,
  parameter int STEP_W   = 8,
  parameter int ENERGY_W = 32,
  parameter int SWEEP_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  sweep_strobe_t              ctl,
  input  logic signed [SAMPLE_W-1:0] sampleI,
  input  logic signed [SAMPLE_W-1:0] sampleQ,
  input  logic [FREQ_W-1:0]          cfgStartFreq,
  input  logic [FREQ_W-1:0]          cfgStepFreq,
  input  logic [STEP_W-1:0]          cfgNumSteps,
  input  logic [ENERGY_W-1:0]        cfgThreshold,
  output logic                       aboveThr,
  output logic                       lastStep,
  output logic [FREQ_W-1:0]          freqWord,
  output logic [STEP_W-1:0]          stepIdx,
  output logic [SWEEP_W-1:0]         sweepCnt
);
  localparam int SQ_W = 2 * SAMPLE_W;

  logic signed [SQ_W-1:0] prodI, prodQ;
  logic [SQ_W:0]          sampleEnergy;
  logic [ENERGY_W:0]      rawSum;
  logic [ENERGY_W-1:0]    satSum;
  logic [ENERGY_W-1:0]    acc;

  assign prodI = sampleI * sampleI;
  assign prodQ = sampleQ * sampleQ;
  assign sampleEnergy = {1'b0, $unsigned(prodI)} + {1'b0, $unsigned(prodQ)};
  assign rawSum = {1'b0, acc} + (ENERGY_W+1)'(sampleEnergy);
  assign satSum = rawSum[ENERGY_W] ? {ENERGY_W{1'b1}} : rawSum[ENERGY_W-1:0];
  assign aboveThr = satSum > cfgThreshold;
  assign lastStep = ({1'b0, stepIdx} + (STEP_W+1)'(1)) >= {1'b0, cfgNumSteps};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      freqWord <= '0;
      stepIdx  <= '0;
      sweepCnt <= '0;
    end else if (ctl.load) begin
      acc      <= '0;
      freqWord <= cfgStartFreq;
      stepIdx  <= '0;
      sweepCnt <= '0;
    end else begin
      if (ctl.dump)       acc <= '0;
      else if (ctl.accum) acc <= satSum;
      if (ctl.advance) begin
        freqWord <= freqWord + cfgStepFreq;
        stepIdx  <= stepIdx + 1'b1;
      end else if (ctl.wrap) begin
        freqWord <= cfgStartFreq;
        stepIdx  <= '0;
        sweepCnt <= sweepCnt + 1'b1;
      end
    end
  end

  // R9: integration never lowers the accumulator, so it cannot wrap
  assert_no_acc_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.accum && !ctl.load && !ctl.dump) |=> (acc >= $past(acc)));
endmodule

// File: rtl/sweep_control.sv
module sweep_control
  import sweep_acq_pkg::*;
#(
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               start,
  input  logic               sampleValid,
  input  logic [DWELL_W-1:0] cfgDwell,
  input  logic               aboveThr,
  input  logic               lastStep,
  output sweep_strobe_t      ctl,
  output logic               searching,
  output logic               locked
);
  sweep_state_t state, nextState;
  logic [DWELL_W-1:0] dwellCnt;
  logic lastSample;

  assign lastSample = ({1'b0, dwellCnt} + (DWELL_W+1)'(1)) >= {1'b0, cfgDwell};

  always_comb begin
    ctl = '0;
    nextState = state;
    if (clear) begin
      ctl.load  = 1'b1;
      nextState = ST_SEARCH;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          ctl.load  = 1'b1;
          nextState = ST_SEARCH;
        end
        ST_SEARCH: if (sampleValid) begin
          if (lastSample) begin
            ctl.dump = 1'b1;
            if (aboveThr)      nextState = ST_LOCK;
            else if (lastStep) ctl.wrap = 1'b1;
            else               ctl.advance = 1'b1;
          end else begin
            ctl.accum = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      dwellCnt <= '0;
    end else begin
      state <= nextState;
      if (ctl.load || ctl.dump) dwellCnt <= '0;
      else if (ctl.accum)       dwellCnt <= dwellCnt + 1'b1;
    end
  end

  assign searching = (state == ST_SEARCH);
  assign locked    = (state == ST_LOCK);

  // R4, R5, R10: at most one of integrate, step and wrap per cycle
  assert_one_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl.accum, ctl.advance, ctl.wrap}));

  // R7: lock persists until a clear
  assert_lock_persists_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clear) |=> locked);
endmodule

// File: rtl/carrier_sweep_acq.sv
module carrier_sweep_acq
  import sweep_acq_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int FREQ_W   = 24,
  parameter int STEP_W   = 8,
  parameter int DWELL_W  = 16,
  parameter int ENERGY_W = 32,
  parameter int SWEEP_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       start,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleI,
  input  logic signed [SAMPLE_W-1:0] sampleQ,
  input  logic [FREQ_W-1:0]          cfgStartFreq,
  input  logic [FREQ_W-1:0]          cfgStepFreq,
  input  logic [STEP_W-1:0]          cfgNumSteps,
  input  logic [DWELL_W-1:0]         cfgDwell,
  input  logic [ENERGY_W-1:0]        cfgThreshold,
  output logic [FREQ_W-1:0]          ncoFreq,
  output logic                       searching,
  output logic                       locked,
  output logic [STEP_W-1:0]          stepIndex,
  output logic [SWEEP_W-1:0]         sweepCount
);
  sweep_strobe_t ctl;
  logic aboveThr, lastStep;

  sweep_control #(.DWELL_W(DWELL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clear(clear), .start(start),
    .sampleValid(sampleValid), .cfgDwell(cfgDwell),
    .aboveThr(aboveThr), .lastStep(lastStep),
    .ctl(ctl), .searching(searching), .locked(locked)
  );

  sweep_datapath #(
    .SAMPLE_W(SAMPLE_W), .FREQ_W(FREQ_W), .STEP_W(STEP_W),
    .ENERGY_W(ENERGY_W), .SWEEP_W(SWEEP_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .sampleI(sampleI), .sampleQ(sampleQ),
    .cfgStartFreq(cfgStartFreq), .cfgStepFreq(cfgStepFreq),
    .cfgNumSteps(cfgNumSteps), .cfgThreshold(cfgThreshold),
    .aboveThr(aboveThr), .lastStep(lastStep),
    .freqWord(ncoFreq), .stepIdx(stepIndex), .sweepCnt(sweepCount)
  );

  // R6, R7: the held frequency word does not move while locked
  assert_hold_freq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clear) |=> $stable(ncoFreq));
endmodule

// File: tb/sim_carrier_sweep_acq.sv
module sim_carrier_sweep_acq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, start = 1'b0, sampleValid = 1'b0;
  logic signed [11:0] sampleI = '0, sampleQ = '0;
  logic [23:0] cfgStartFreq = '0, cfgStepFreq = '0;
  logic [7:0]  cfgNumSteps = '0;
  logic [15:0] cfgDwell = '0;
  logic [31:0] cfgThreshold = '0;
  logic [23:0] ncoFreq;
  logic searching, locked;
  logic [7:0] stepIndex, sweepCount;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  carrier_sweep_acq u0 (
    .clk(clk), .rst_n(rst_n), .clear(clear), .start(start),
    .sampleValid(sampleValid), .sampleI(sampleI), .sampleQ(sampleQ),
    .cfgStartFreq(cfgStartFreq), .cfgStepFreq(cfgStepFreq),
    .cfgNumSteps(cfgNumSteps), .cfgDwell(cfgDwell), .cfgThreshold(cfgThreshold),
    .ncoFreq(ncoFreq), .searching(searching), .locked(locked),
    .stepIndex(stepIndex), .sweepCount(sweepCount)
  );

  typedef struct packed {
    logic [23:0] startF;
    logic [23:0] stepF;
    logic [7:0]  nSteps;
    logic [15:0] dwell;
    logic [31:0] thr;
    logic [7:0]  peakIdx;
    logic [7:0]  peakSweep;
  } vec_t;

  // small sample 3,4 -> 25 per sample; big sample 100,0 -> 10000 per sample
  localparam vec_t VECS [0:4] = '{
    '{24'h100000, 24'h001000, 8'd8, 16'd4, 32'd1000, 8'd5, 8'd0},
    '{24'hFFF000, 24'h000800, 8'd6, 16'd3, 32'd500,  8'd4, 8'd0},
    '{24'h200000, 24'h000010, 8'd3, 16'd2, 32'd300,  8'd1, 8'd1},
    '{24'h0ABCDE, 24'h000100, 8'd0, 16'd0, 32'd100,  8'd0, 8'd2},
    '{24'h000777, 24'h000001, 8'd1, 16'd5, 32'd2000, 8'd0, 8'd0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic setSmall();
    sampleI = 12'sd3; sampleQ = 12'sd4;
  endtask

  task automatic setBig();
    sampleI = 12'sd100; sampleQ = 12'sd0;
  endtask

  task automatic pulseClear();
    clear = 1'b1; cyc(); clear = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    cyc(); cyc();
    check("R1 ncoFreq in reset", 64'(ncoFreq), 64'd0);
    check("R1 flags in reset", 64'({searching, locked}), 64'd0);
    rst_n = 1'b1;
    cyc();
    check("R1 outputs after reset", 64'({ncoFreq, stepIndex, sweepCount, searching, locked}), 64'd0);

    // R2: start from idle
    cfgStartFreq = 24'h123456; cfgStepFreq = 24'h000010; cfgNumSteps = 8'd4;
    cfgDwell = 16'd4; cfgThreshold = 32'd1000;
    start = 1'b1; cyc(); start = 1'b0;
    check("R2 searching", 64'(searching), 64'd1);
    check("R2 ncoFreq", 64'(ncoFreq), 64'h123456);
    check("R2 index/sweeps", 64'({stepIndex, sweepCount}), 64'd0);

    // R3/R4: dwell counts only valid samples
    setSmall();
    sampleValid = 1'b1; cyc();
    sampleValid = 1'b0; cyc();
    sampleValid = 1'b1; cyc(); cyc();
    sampleValid = 1'b0; cyc();
    check("R3 no step after 3 valid samples", 64'(stepIndex), 64'd0);
    sampleValid = 1'b1; cyc();
    sampleValid = 1'b0;
    check("R4 index after dwell", 64'(stepIndex), 64'd1);
    check("R4 ncoFreq stepped", 64'(ncoFreq), 64'h123466);

    // R11: start while searching ignored
    start = 1'b1; cyc(); start = 1'b0;
    check("R11 index unchanged", 64'(stepIndex), 64'd1);
    check("R11 ncoFreq unchanged", 64'(ncoFreq), 64'h123466);

    // R10/R5: 12 dwells of 100 each never accumulate past 1000
    sampleValid = 1'b1;
    repeat (48) cyc();
    sampleValid = 1'b0;
    check("R10 still searching", 64'({searching, locked}), 64'b10);
    check("R5 sweeps after wraps", 64'(sweepCount), 64'd3);
    check("R5 index after wraps", 64'(stepIndex), 64'd1);
    check("R4 ncoFreq at index 1", 64'(ncoFreq), 64'h123466);

    // R6/R3: strict threshold comparison
    cfgThreshold = 32'd100;
    pulseClear();
    check("R8 clear restarts", 64'({ncoFreq, stepIndex, sweepCount}), {24'h123456, 16'd0});
    sampleValid = 1'b1; repeat (4) cyc(); sampleValid = 1'b0;
    check("R6 energy equal to threshold no lock", 64'({locked, stepIndex}), {1'b0, 8'd1});
    cfgThreshold = 32'd99;
    sampleValid = 1'b1; repeat (3) cyc();
    check("R3 no lock before dwell end", 64'(locked), 64'd0);
    cyc(); sampleValid = 1'b0;
    check("R6 locked above threshold", 64'({searching, locked}), 64'b01);
    check("R6 held index", 64'(stepIndex), 64'd1);
    check("R6 held ncoFreq", 64'(ncoFreq), 64'h123466);

    // R7: samples and start ignored while locked
    setBig(); sampleValid = 1'b1;
    repeat (10) cyc();
    start = 1'b1; cyc(); start = 1'b0; cyc();
    sampleValid = 1'b0;
    check("R7 still locked", 64'({searching, locked}), 64'b01);
    check("R7 frequency and index held", 64'({ncoFreq, stepIndex}), {24'h123466, 8'd1});

    // R8: clear with start in the same cycle while locked
    clear = 1'b1; start = 1'b1; cyc(); clear = 1'b0; start = 1'b0;
    check("R8 flags after clear", 64'({searching, locked}), 64'b10);
    check("R8 state after clear", 64'({ncoFreq, stepIndex, sweepCount}), {24'h123456, 16'd0});

    // R9: saturation; true energy 8388608000 wraps to 4093640704 if not saturated
    cfgDwell = 16'd1000; cfgThreshold = 32'hFFFF_FFFE;
    pulseClear();
    sampleI = -12'sd2048; sampleQ = -12'sd2048; sampleValid = 1'b1;
    repeat (999) cyc();
    check("R9 no lock before dwell end", 64'({searching, locked, stepIndex}), {2'b10, 8'd0});
    cyc(); sampleValid = 1'b0;
    check("R9 saturated dwell locks", 64'({locked, stepIndex}), {1'b1, 8'd0});

    // Vector table: sweeps that halt at a programmed point
    foreach (VECS[v]) begin
      int n;
      logic [23:0] expF;
      cfgStartFreq = VECS[v].startF; cfgStepFreq = VECS[v].stepF;
      cfgNumSteps = VECS[v].nSteps; cfgDwell = VECS[v].dwell;
      cfgThreshold = VECS[v].thr;
      sampleValid = 1'b0;
      pulseClear();
      n = 0;
      while (!locked && n < 3000) begin
        if (stepIndex == VECS[v].peakIdx && sweepCount >= VECS[v].peakSweep) setBig();
        else setSmall();
        sampleValid = 1'b1;
        cyc();
        n++;
      end
      sampleValid = 1'b0;
      expF = VECS[v].startF + 24'(VECS[v].peakIdx) * VECS[v].stepF;
      check($sformatf("R6 vector %0d locked", v), 64'({searching, locked}), 64'b01);
      check($sformatf("R4 vector %0d held ncoFreq", v), 64'(ncoFreq), 64'(expF));
      check($sformatf("R6 vector %0d held index", v), 64'(stepIndex), 64'(VECS[v].peakIdx));
      check($sformatf("R5 vector %0d sweeps", v), 64'(sweepCount), 64'(VECS[v].peakSweep));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule